// File: doc/BRIEF.md
# Skip-Class Condition Evaluator

This block decides, for a 16-bit machine, whether an instruction in the skip class should make the program counter step over the next word. It looks at the instruction word, the accumulator, the carry bit, a memory parity error flag and four sense switch inputs. It returns one request bit. The program counter logic uses that bit to advance by two instead of one. Updating the program counter and detecting parity errors are done elsewhere.

The low nine bits of a skip word form a selection mask. Each set bit picks one test. With the reverse bit clear, the block asks for a skip only when every picked test holds. An empty mask therefore skips unconditionally. With the reverse bit set, the decision is inverted, so the same mask expresses "skip if any picked test fails".

The zero test is not independent of the sign and parity tests: a zero accumulator is also positive and even. As a result, "skip if the accumulator is strictly positive" cannot be written as a mask. The block is purely combinational, and its output is meaningful whenever the instruction-valid input is high.

Top module: `skip_eval`

## Requirements
- R1: `skip_req` is low unless `instr_valid` is high and `instr[15:10]` equals binary 100000.
- R2: A skip word whose bits 9..0 are all zero (octal 100000) always requests a skip.
- R3: Bit 9 is the reverse bit, and it inverts the combined decision. Octal 101000 never skips, and octal 101001 skips exactly when `carry` is high.
- R4: Bit 8 selects the test "accumulator positive". This test is true when `acc[15]` is 0, so zero counts as positive.
- R5: Bit 6 selects the test "accumulator even". This test is true when `acc[0]` is 0.
- R6: Bit 5 selects the test "accumulator zero". This test is true when all 16 bits of `acc` are 0.
- R7: Bit 7 selects the test "memory parity error". This test is true when `parity_err` is high.
- R8: Bits 4, 3, 2 and 1 select the tests "sense switch 1, 2, 3, 4 is reset". These bits read `sense_sw[0]`, `[1]`, `[2]` and `[3]` respectively, and each test is true when that input is 0. Octal 100030 skips only when switches 1 and 2 are both reset. Octal 101030 skips when either of them is set.
- R9: Bit 0 selects the test "carry zero". This test is true when `carry` is 0.
- R10: With bit 9 clear, a skip is requested exactly when every selected test is true. For example, octal 100500 skips only on a positive even accumulator, and octal 100041 skips only when the accumulator and the carry are both zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 16 | Instruction word |
| acc | input | 16 | Accumulator contents, bit 15 is the sign |
| carry | input | 1 | Carry bit |
| parity_err | input | 1 | Memory parity error flag |
| sense_sw | input | 4 | Sense switches, bit k high means switch k+1 is set |
| skip_req | output | 1 | Request to skip the next instruction |

## Verification
Some rules are checked at all times by immediate assertions. These are: no request outside a valid skip-class word, the empty mask always skipping, the reversed empty mask never skipping, and the single-test zero and carry masks following their inputs. How the tests combine for arbitrary masks, and how that combination inverts, can only be shown by the bench scenarios. The bench sweeps every one of the 1024 low-field patterns against corner accumulator values and every switch, carry and parity setting, and adds the directed example words.

// File: rtl/skip_pkg.sv
package skip_pkg;
    localparam int WORD_W   = 16;
    localparam int ACC_W    = 16;
    localparam int SW_N     = 4;
    localparam int CLASS_W  = 6;
    localparam int COND_N   = 9;
    localparam int REV_POS  = COND_N;
    localparam logic [CLASS_W-1:0] CLASS_CODE = 6'b100000;

    // Bit position of each test inside the selection field.
    typedef enum int {
        SEL_CARRY  = 0,
        SEL_SW_LO  = 1,
        SEL_ZERO   = 5,
        SEL_EVEN   = 6,
        SEL_PARITY = 7,
        SEL_POS    = 8
    } sel_pos_e;
endpackage

// File: rtl/skip_cond_gen.sv
module skip_cond_gen
    import skip_pkg::*;
(
    input  logic [ACC_W-1:0]  acc,
    input  logic              carry,
    input  logic              parity_err,
    input  logic [SW_N-1:0]   sense_sw,
    output logic [COND_N-1:0] cond_true
);
    logic acc_is_zero;
    assign acc_is_zero = (acc == '0);

    always_comb begin
        cond_true[SEL_CARRY]  = ~carry;
        cond_true[SEL_ZERO]   = acc_is_zero;
        cond_true[SEL_EVEN]   = ~acc[0];
        cond_true[SEL_PARITY] = parity_err;
        cond_true[SEL_POS]    = ~acc[ACC_W-1];
    end

    // Switch 1 sits at the highest switch position, switch SW_N at the lowest.
    genvar k;
    generate
        for (k = 0; k < SW_N; k++) begin : g_sw
            assign cond_true[SEL_SW_LO + (SW_N - 1 - k)] = ~sense_sw[k];
        end
    endgenerate
endmodule

// File: rtl/skip_mask_and.sv
module skip_mask_and
    import skip_pkg::*;
(
    input  logic [COND_N-1:0] sel,
    input  logic [COND_N-1:0] cond_true,
    output logic              all_met
);
    logic [COND_N-1:0] pass;

    genvar i;
    generate
        for (i = 0; i < COND_N; i++) begin : g_pass
            assign pass[i] = cond_true[i] | ~sel[i];
        end
    endgenerate

    assign all_met = &pass;
endmodule

// File: rtl/skip_eval.sv
module skip_eval
    import skip_pkg::*;
(
    input  logic              instr_valid,
    input  logic [WORD_W-1:0] instr,
    input  logic [ACC_W-1:0]  acc,
    input  logic              carry,
    input  logic              parity_err,
    input  logic [SW_N-1:0]   sense_sw,
    output logic              skip_req
);
    logic [COND_N-1:0] cond_true;
    logic              all_met;
    logic              class_hit;
    logic              reverse;

    assign class_hit = (instr[WORD_W-1 -: CLASS_W] == CLASS_CODE);
    assign reverse   = instr[REV_POS];

    skip_cond_gen u_cond (
        .acc        (acc),
        .carry      (carry),
        .parity_err (parity_err),
        .sense_sw   (sense_sw),
        .cond_true  (cond_true)
    );

    skip_mask_and u_and (
        .sel       (instr[COND_N-1:0]),
        .cond_true (cond_true),
        .all_met   (all_met)
    );

    assign skip_req = instr_valid & class_hit & (all_met ^ reverse);
endmodule

// File: rtl/skip_eval_chk.sv
module skip_eval_chk
    import skip_pkg::*;
(
    input logic              instr_valid,
    input logic [WORD_W-1:0] instr,
    input logic [ACC_W-1:0]  acc,
    input logic              carry,
    input logic              skip_req
);
    logic live;
    assign live = instr_valid && (instr[15:10] == 6'b100000);

    always_comb begin
        if (skip_req)
            a_r1_class_gate: assert (live);
        if (live && instr[9:0] == 10'h000)
            a_r2_empty_skips: assert (skip_req);
        if (live && instr[9:0] == 10'h200)
            a_r3_rev_never: assert (!skip_req);
        if (live && instr[9:0] == 10'h020)
            a_r6_zero_only: assert (skip_req == (acc == 16'h0000));
        if (live && instr[9:0] == 10'h001)
            a_r9_carry_only: assert (skip_req == !carry);
    end
endmodule

bind skip_eval skip_eval_chk u_chk (
    .instr_valid (instr_valid),
    .instr       (instr),
    .acc         (acc),
    .carry       (carry),
    .skip_req    (skip_req)
);

// File: tb/skip_eval_tb.sv
module skip_eval_tb;
    logic        clk = 1'b0;
    logic        instr_valid;
    logic [15:0] instr;
    logic [15:0] acc;
    logic        carry;
    logic        parity_err;
    logic [3:0]  sense_sw;
    logic        skip_req;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    skip_eval u_dut (
        .instr_valid (instr_valid),
        .instr       (instr),
        .acc         (acc),
        .carry       (carry),
        .parity_err  (parity_err),
        .sense_sw    (sense_sw),
        .skip_req    (skip_req)
    );

    function automatic logic model(input logic v, input logic [15:0] w,
                                   input logic [15:0] a, input logic c,
                                   input logic pe, input logic [3:0] sw);
        logic ok;
        if (!v || w[15:10] != 6'b100000) return 1'b0;
        ok = 1'b1;
        if (w[8] && a[15] != 1'b0) ok = 1'b0;   // R4
        if (w[7] && !pe)           ok = 1'b0;   // R7
        if (w[6] && a[0] != 1'b0)  ok = 1'b0;   // R5
        if (w[5] && a != 16'h0)    ok = 1'b0;   // R6
        if (w[4] && sw[0])         ok = 1'b0;   // R8 switch 1
        if (w[3] && sw[1])         ok = 1'b0;
        if (w[2] && sw[2])         ok = 1'b0;
        if (w[1] && sw[3])         ok = 1'b0;
        if (w[0] && c)             ok = 1'b0;   // R9
        return w[9] ? !ok : ok;                 // R3, R10
    endfunction

    task automatic apply(input logic v, input logic [15:0] w, input logic [15:0] a,
                         input logic c, input logic pe, input logic [3:0] sw);
        instr_valid = v; instr = w; acc = a; carry = c; parity_err = pe; sense_sw = sw;
        #1;
    endtask

    task automatic chk(input string tag, input logic exp);
        total++;
        if (skip_req !== exp) begin
            bad++;
            $display("FAIL %s instr=%o acc=%h c=%b pe=%b sw=%b got=%b exp=%b",
                     tag, instr, acc, carry, parity_err, sense_sw, skip_req, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (!done && cycles > 150000) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] corners [5];
        corners[0] = 16'h0000; corners[1] = 16'h0001; corners[2] = 16'hFFFF;
        corners[3] = 16'h8000; corners[4] = 16'h7FFF;

        // Idle state: no request while nothing is valid
        apply(1'b0, 16'o100000, 16'h0, 1'b0, 1'b0, 4'h0);
        chk("R1 idle", 1'b0);
        apply(1'b0, 16'o100000, 16'h1234, 1'b1, 1'b1, 4'hF);
        chk("R1 valid low", 1'b0);
        // R1: other classes never request
        apply(1'b1, 16'o140000, 16'h0, 1'b0, 1'b0, 4'h0);
        chk("R1 generic A class", 1'b0);
        apply(1'b1, 16'o040000, 16'h0, 1'b0, 1'b0, 4'h0);
        chk("R1 shift class", 1'b0);
        apply(1'b1, 16'o100100 | 16'o002000, 16'h0, 1'b0, 1'b0, 4'h0);
        chk("R1 op field nonzero", 1'b0);
        // R2
        apply(1'b1, 16'o100000, 16'hABCD, 1'b1, 1'b0, 4'hF);
        chk("R2 unconditional", 1'b1);
        // R3
        apply(1'b1, 16'o101000, 16'h0, 1'b0, 1'b1, 4'h0);
        chk("R3 never skip", 1'b0);
        apply(1'b1, 16'o101001, 16'h0, 1'b1, 1'b0, 4'h0);
        chk("R3 skip on carry set", 1'b1);
        apply(1'b1, 16'o101001, 16'h0, 1'b0, 1'b0, 4'h0);
        chk("R3 no skip carry clear", 1'b0);
        // R4: zero counts as positive
        apply(1'b1, 16'o100400, 16'h0000, 1'b0, 1'b0, 4'h0);
        chk("R4 zero positive", 1'b1);
        apply(1'b1, 16'o100400, 16'h8000, 1'b0, 1'b0, 4'h0);
        chk("R4 negative", 1'b0);
        // R5
        apply(1'b1, 16'o100100, 16'h0003, 1'b0, 1'b0, 4'h0);
        chk("R5 odd", 1'b0);
        apply(1'b1, 16'o100100, 16'hFFFE, 1'b0, 1'b0, 4'h0);
        chk("R5 even", 1'b1);
        // R6
        apply(1'b1, 16'o100040, 16'h0100, 1'b0, 1'b0, 4'h0);
        chk("R6 nonzero", 1'b0);
        // R7
        apply(1'b1, 16'o100200, 16'h0, 1'b0, 1'b1, 4'h0);
        chk("R7 parity set", 1'b1);
        apply(1'b1, 16'o100200, 16'h0, 1'b0, 1'b0, 4'h0);
        chk("R7 parity clear", 1'b0);
        // R8
        apply(1'b1, 16'o100030, 16'h0, 1'b0, 1'b0, 4'b1100);
        chk("R8 sw1 sw2 reset", 1'b1);
        apply(1'b1, 16'o100030, 16'h0, 1'b0, 1'b0, 4'b0010);
        chk("R8 sw2 set", 1'b0);
        apply(1'b1, 16'o101030, 16'h0, 1'b0, 1'b0, 4'b0001);
        chk("R8 either set", 1'b1);
        apply(1'b1, 16'o100002, 16'h0, 1'b0, 1'b0, 4'b1000);
        chk("R8 sw4 set", 1'b0);
        // R9
        apply(1'b1, 16'o100001, 16'h0, 1'b1, 1'b0, 4'h0);
        chk("R9 carry set", 1'b0);
        // R10
        apply(1'b1, 16'o100500, 16'h0002, 1'b0, 1'b0, 4'h0);
        chk("R10 positive even", 1'b1);
        apply(1'b1, 16'o100500, 16'h8002, 1'b0, 1'b0, 4'h0);
        chk("R10 negative even", 1'b0);
        apply(1'b1, 16'o100041, 16'h0000, 1'b0, 1'b0, 4'h0);
        chk("R10 A and C zero", 1'b1);
        apply(1'b1, 16'o100041, 16'h0000, 1'b1, 1'b0, 4'h0);
        chk("R10 C set", 1'b0);

        // R10 sweep: all 1024 low fields against corner inputs
        for (int m = 0; m < 1024; m++) begin
            for (int ai = 0; ai < 5; ai++) begin
                for (int s = 0; s < 16; s++) begin
                    for (int cp = 0; cp < 4; cp++) begin
                        apply(1'b1, {6'b100000, m[9:0]}, corners[ai], cp[0], cp[1], s[3:0]);
                        chk("R10 sweep",
                            model(1'b1, {6'b100000, m[9:0]}, corners[ai], cp[0], cp[1], s[3:0]));
                    end
                end
            end
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule